// File: doc/BRIEF.md
# Mode-Selectable Dual Performance Counter

This block holds two event counters whose inputs are picked by a small control register. Each clock cycle the block receives single-cycle event strobes: an instruction-retire strobe, a cycle tick, a cache-miss/long-latency-probe strobe, a replay-trap strobe and a retire-delay strobe. A mode bit selects between aggregate counting and sampling-profile counting. A two-bit select field is shared by both counters. Together the mode and the select decide which strobe each counter follows. One combination gives the second counter no event at all.

Each counter adds one in any cycle where counting is enabled and its selected strobe is high. When a counter wraps from all ones to zero, its overflow flag is set. The flag stays set until a control write clears it. Control writes take effect at the clock edge that captures them. Any increment at that same edge still follows the old selection.

Top module: `perf_dual_counter`

## Requirements
- R1: After a synchronous reset both counters read zero, both overflow flags read zero, and the control register holds mode aggregate, select 00 and counting disabled.
- R2: A control write stores ctl_wdata bit 4 as the mode (0 aggregate, 1 profile), bits 3:2 as the select and bit 1 as the enable. The new setting applies from the capturing edge onward, and an increment at that same edge uses the previous setting.
- R3: While the enable bit is 0, neither counter changes, whatever the event strobes do.
- R4: In either mode, counter 0 follows the retire strobe when select bit 2 is 0 and the cycle tick when select bit 2 is 1.
- R5: In either mode, counter 1 follows the cycle tick for select 00, the probe strobe for select 10 and the replay strobe for select 11.
- R6: In profile mode with select 01, counter 1 follows the retire-delay strobe.
- R7: In aggregate mode with select 01, counter 1 holds its value even when every strobe is high.
- R8: A counter is CNT_W bits wide (20 by default), rises by exactly one per cycle with its selected strobe high while enabled, and wraps from all ones to zero.
- R9: A wrap sets that counter's overflow flag, and the flag then stays set through later counting.
- R10: A control write with bit 0 set clears both overflow flags at its edge, unless that counter wraps at the same edge, in which case its flag is set. A control write with bit 0 clear leaves the flags unchanged.
- R11: Strobes that are not selected for a counter have no effect on that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control data: [4] mode, [3:2] select, [1] enable, [0] clear overflow flags |
| ev_retire | input | 1 | Instruction retired this cycle |
| ev_tick | input | 1 | Cycle tick |
| ev_probe | input | 1 | Cache miss or long-latency probe |
| ev_replay | input | 1 | Replay trap |
| ev_rdelay | input | 1 | Retire-delay event (profile mode only) |
| cnt0_o | output | CNT_W | Counter 0 value |
| cnt1_o | output | CNT_W | Counter 1 value |
| ovf0_o | output | 1 | Counter 0 sticky overflow |
| ovf1_o | output | 1 | Counter 1 sticky overflow |

## Verification
Every result of this block is due at the first rising edge after its stimulus. This holds for a counter increment, a wrap with its flag, a flag clear and the switch to a new selection. The driver applies one cycle of strobes and control at the falling edge and predicts the post-edge counter and flag values from the selection in force before that edge. It then queues the prediction. The monitor compares each queued item 1 ns after the next rising edge, so a check never reads a value from the middle of an edge.

// File: rtl/perfc_pkg.sv
package perfc_pkg;

  localparam int CTL_W = 5;

  // control word bit positions
  localparam int CB_CLR  = 0;
  localparam int CB_ENA  = 1;
  localparam int CB_SELL = 2;
  localparam int CB_SELH = 3;
  localparam int CB_MODE = 4;

  typedef enum logic {
    MODE_AGG  = 1'b0,
    MODE_PROF = 1'b1
  } perf_mode_e;

  typedef enum logic [1:0] {
    SEL_A = 2'b00,
    SEL_B = 2'b01,
    SEL_C = 2'b10,
    SEL_D = 2'b11
  } perf_sel_e;

  typedef struct packed {
    perf_mode_e mode;
    perf_sel_e  sel;
    logic       ena;
  } perf_ctl_t;

  typedef struct packed {
    logic retire;
    logic tick;
    logic probe;
    logic replay;
    logic rdelay;
  } perf_ev_t;

endpackage

// File: rtl/perfc_ctl_reg.sv
module perfc_ctl_reg
  import perfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output perf_ctl_t        ctl,
  output logic             clr_ovf
);

  perf_ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '{mode: MODE_AGG, sel: SEL_A, ena: 1'b0};
    end else if (we) begin
      ctl_q.mode <= perf_mode_e'(wdata[CB_MODE]);
      ctl_q.sel  <= perf_sel_e'(wdata[CB_SELH:CB_SELL]);
      ctl_q.ena  <= wdata[CB_ENA];
    end
  end

  assign ctl     = ctl_q;
  assign clr_ovf = we & wdata[CB_CLR];

endmodule

// File: rtl/perfc_src_sel.sv
module perfc_src_sel
  import perfc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  perf_ctl_t ctl,
  input  perf_ev_t  ev,
  output logic      hit
);

  logic raw;

  generate
    if (IDX == 0) begin : g_c0
      always_comb begin
        raw = ctl.sel[0] ? ev.tick : ev.retire;
      end
    end else begin : g_c1
      always_comb begin
        unique case (ctl.sel)
          SEL_A:   raw = ev.tick;
          SEL_B:   raw = (ctl.mode == MODE_PROF) ? ev.rdelay : 1'b0;
          SEL_C:   raw = ev.probe;
          SEL_D:   raw = ev.replay;
          default: raw = 1'b0;
        endcase
      end
    end
  endgenerate

  assign hit = ctl.ena & raw;

endmodule

// File: rtl/perfc_count.sv
module perfc_count #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = inc & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (inc) cnt_q <= cnt_q + 1'b1;
      if (wrap)         ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

endmodule

// File: rtl/perf_dual_counter.sv
module perf_dual_counter
  import perfc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [4:0]       ctl_wdata,
  input  logic             ev_retire,
  input  logic             ev_tick,
  input  logic             ev_probe,
  input  logic             ev_replay,
  input  logic             ev_rdelay,
  output logic [CNT_W-1:0] cnt0_o,
  output logic [CNT_W-1:0] cnt1_o,
  output logic             ovf0_o,
  output logic             ovf1_o
);

  localparam int NCNT = 2;

  perf_ctl_t        ctl;
  logic             clr_ovf;
  perf_ev_t         ev;
  logic [NCNT-1:0]  inc;
  logic [CNT_W-1:0] cnt [NCNT];
  logic [NCNT-1:0]  ovf;

  // observation points for the checker
  logic       ena_w;
  logic       mode_w;
  logic [1:0] sel_w;

  assign ev = '{retire: ev_retire, tick: ev_tick, probe: ev_probe,
                replay: ev_replay, rdelay: ev_rdelay};

  perfc_ctl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .ctl     (ctl),
    .clr_ovf (clr_ovf)
  );

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      perfc_src_sel #(.IDX(i)) u_sel (
        .ctl (ctl),
        .ev  (ev),
        .hit (inc[i])
      );
      perfc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc[i]),
        .clr_ovf (clr_ovf),
        .cnt     (cnt[i]),
        .ovf     (ovf[i])
      );
    end
  endgenerate

  assign cnt0_o = cnt[0];
  assign cnt1_o = cnt[1];
  assign ovf0_o = ovf[0];
  assign ovf1_o = ovf[1];

  assign ena_w  = ctl.ena;
  assign mode_w = ctl.mode;
  assign sel_w  = ctl.sel;

endmodule

// File: rtl/perf_dual_counter_chk.sv
module perf_dual_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_we,
  input logic [4:0]       ctl_wdata,
  input logic             ena,
  input logic             mode,
  input logic [1:0]       sel,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic             ovf0,
  input logic             ovf1
);

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R3
  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (seen && !ena) |=> ($stable(cnt0) && $stable(cnt1)));

  // R7
  a_r7_undef_holds: assert property (@(posedge clk) disable iff (rst)
    (seen && !mode && sel == 2'b01) |=> $stable(cnt1));

  // R8
  a_r8_step_c0: assert property (@(posedge clk) disable iff (rst)
    seen |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 1'b1));

  a_r8_step_c1: assert property (@(posedge clk) disable iff (rst)
    seen |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + 1'b1));

  // R9
  a_r9_sticky0: assert property (@(posedge clk) disable iff (rst)
    (seen && ovf0 && !(ctl_we && ctl_wdata[0])) |=> ovf0);

  a_r9_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (seen && $rose(ovf1)) |-> (cnt1 == '0));

  // R10
  a_r10_keep_flags: assert property (@(posedge clk) disable iff (rst)
    (seen && ovf1 && ctl_we && !ctl_wdata[0]) |=> ovf1);

endmodule

bind perf_dual_counter perf_dual_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ena       (ena_w),
  .mode      (mode_w),
  .sel       (sel_w),
  .cnt0      (cnt0_o),
  .cnt1      (cnt1_o),
  .ovf0      (ovf0_o),
  .ovf1      (ovf1_o)
);

// File: tb/sim_perf_dual_counter.sv
`timescale 1ns/1ps
module sim_perf_dual_counter;

  localparam int W = 8;
  localparam logic [W-1:0] TOP = '1;

  // strobe vector bits
  localparam int E_RET = 4, E_TCK = 3, E_PRB = 2, E_RPL = 1, E_RDL = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] evs = '0;
  logic [W-1:0] cnt0, cnt1;
  logic ovf0, ovf1;

  always #2 clk = ~clk;   // 250 MHz

  perf_dual_counter #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ev_retire(evs[E_RET]), .ev_tick(evs[E_TCK]), .ev_probe(evs[E_PRB]),
    .ev_replay(evs[E_RPL]), .ev_rdelay(evs[E_RDL]),
    .cnt0_o(cnt0), .cnt1_o(cnt1), .ovf0_o(ovf0), .ovf1_o(ovf1)
  );

  typedef struct {
    logic [W-1:0] c0, c1;
    logic o0, o1;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [W-1:0] m_c0 = '0, m_c1 = '0;
  logic m_o0 = 0, m_o1 = 0;
  logic m_mode = 0, m_ena = 0;
  logic [1:0] m_sel = '0;

  function automatic logic pick0(logic [1:0] s, logic [4:0] e);
    return s[0] ? e[E_TCK] : e[E_RET];               // R4
  endfunction

  function automatic logic pick1(logic md, logic [1:0] s, logic [4:0] e);
    case (s)
      2'b00: return e[E_TCK];                          // R5
      2'b01: return md ? e[E_RDL] : 1'b0;              // R6, R7
      2'b10: return e[E_PRB];                          // R5
      default: return e[E_RPL];                        // R5
    endcase
  endfunction

  task automatic cyc(input logic we, input logic [4:0] wd,
                     input logic [4:0] e, input string tag);
    logic i0, i1, w0, w1, clr;
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; evs = e;
    i0 = m_ena & pick0(m_sel, e);
    i1 = m_ena & pick1(m_mode, m_sel, e);
    w0 = i0 && (m_c0 == TOP);
    w1 = i1 && (m_c1 == TOP);
    clr = we & wd[0];
    if (i0) m_c0 = m_c0 + 1'b1;
    if (i1) m_c1 = m_c1 + 1'b1;
    m_o0 = w0 ? 1'b1 : (clr ? 1'b0 : m_o0);
    m_o1 = w1 ? 1'b1 : (clr ? 1'b0 : m_o1);
    if (we) begin
      m_mode = wd[4]; m_sel = wd[3:2]; m_ena = wd[1];
    end
    q.push_back('{c0: m_c0, c1: m_c1, o0: m_o0, o1: m_o1, tag: tag});
  endtask

  function automatic logic [4:0] cw(logic md, logic [1:0] s, logic en, logic cl);
    return {md, s, en, cl};
  endfunction

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (cnt0 !== x.c0 || cnt1 !== x.c1 || ovf0 !== x.o0 || ovf1 !== x.o1) begin
        errors++;
        $display("FAIL %s: got c0=%0d c1=%0d o0=%0b o1=%0b exp c0=%0d c1=%0d o0=%0b o1=%0b",
                 x.tag, cnt0, cnt1, ovf0, ovf1, x.c0, x.c1, x.o0, x.o1);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (cnt0 !== '0 || cnt1 !== '0 || ovf0 !== 1'b0 || ovf1 !== 1'b0) begin
      errors++;
      $display("FAIL R1: got c0=%0d c1=%0d o0=%0b o1=%0b exp 0 0 0 0", cnt0, cnt1, ovf0, ovf1);
    end
    // R3 disabled: all strobes ignored
    repeat (3) cyc(0, '0, 5'b11111, "R3");
    // R2: enable with agg sel00; same-edge strobes use old (disabled) setting
    cyc(1, cw(0, 2'b00, 1, 0), 5'b11111, "R2");
    // R4 retire / R5 tick, R11 others ignored
    cyc(0, '0, 5'b10000, "R4");
    cyc(0, '0, 5'b01000, "R5");
    cyc(0, '0, 5'b00111, "R11");
    cyc(0, '0, 5'b11000, "R4");
    // R7 aggregate sel01: counter 1 holds even with everything high
    cyc(1, cw(0, 2'b01, 1, 0), 5'b00000, "R2");
    repeat (3) cyc(0, '0, 5'b11111, "R7");
    cyc(0, '0, 5'b10001, "R11");
    // R5 probe / replay in aggregate
    cyc(1, cw(0, 2'b10, 1, 0), 5'b01000, "R2");
    cyc(0, '0, 5'b00100, "R5");
    cyc(0, '0, 5'b01011, "R11");
    cyc(1, cw(0, 2'b11, 1, 0), 5'b00100, "R2");
    cyc(0, '0, 5'b00010, "R5");
    cyc(0, '0, 5'b11101, "R4");
    // profile mode
    cyc(1, cw(1, 2'b01, 1, 0), 5'b00010, "R2");
    cyc(0, '0, 5'b00001, "R6");
    cyc(0, '0, 5'b11110, "R6");
    cyc(1, cw(1, 2'b00, 1, 0), 5'b00001, "R2");
    cyc(0, '0, 5'b11000, "R5");
    cyc(1, cw(1, 2'b10, 1, 0), 5'b01000, "R2");
    cyc(0, '0, 5'b10100, "R5");
    cyc(1, cw(1, 2'b11, 1, 0), 5'b00100, "R2");
    cyc(0, '0, 5'b00010, "R5");
    // R8/R9 wrap counter 0 on ticks (profile sel01), counter 1 idle
    cyc(1, cw(1, 2'b01, 1, 0), 5'b00000, "R2");
    while (m_c0 != TOP) cyc(0, '0, 5'b01000, "R8");
    cyc(0, '0, 5'b01000, "R9");
    repeat (3) cyc(0, '0, 5'b01000, "R9");
    // R10 write without clear keeps flag
    cyc(1, cw(1, 2'b01, 1, 0), 5'b00000, "R10");
    // R10 clear
    cyc(1, cw(1, 2'b01, 1, 1), 5'b00000, "R10");
    // wrap counter 1 on retire-delay, with clear at the wrap edge
    while (m_c1 != TOP) cyc(0, '0, 5'b00001, "R8");
    cyc(1, cw(1, 2'b01, 1, 1), 5'b00001, "R10");
    cyc(0, '0, 5'b00000, "R9");
    // R3 disable again
    cyc(1, cw(1, 2'b00, 0, 0), 5'b11111, "R2");
    repeat (2) cyc(0, '0, 5'b11111, "R3");
    @(negedge clk);
    ctl_we = 0; evs = '0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule